// File: doc/BRIEF.md
# Dual-host register bank

A small bank of control and status registers shared by two independent host ports, called primary and secondary. Each port is a plain synchronous bus with a register index, write data, a write strobe, a read strobe and registered read data. Every bit of the bank has its own fixed configuration: a write policy, a reset domain, an owning port and a default value. Hardware inputs can raise status bits, and some bits take their default by sampling an external level.

Three resets are nested. Power-good low holds every bit at its default. The global (primary-host) reset restores ordinary bits only. The secondary-host reset restores only bits in the secondary domain. When both ports write the same register in one cycle, the primary write is applied first and the secondary write is then applied to the result. A hardware set event wins over a clearing write in the same cycle. All resets and strobes are synchronous and active high, except `pwr_good`, which resets while it is low.

The bit layout is fixed by index for the default size of 4 registers of 8 bits. Register 0 is read/write. Register 1 has one bit of each policy. Register 2 holds the reset-domain bits. Register 3 holds the port-owned bits.

Top module: `dualhost_regbank`

## Requirements
- R1: Read data appears on the port's read data one cycle after the read strobe. It shows the register as it was before any write in that same cycle. In a cycle after no read strobe, the read data is 0.
- R2: After `pwr_good` has been low and is then high, the registers read as follows: register 0 reads 0x49 (bits 0, 3 and 6 set); register 1 reads 0x40 (only bit 6 set); register 2 bits 0 to 5 read 1; register 3 reads 0x00.
- R3: Read/write bits take the written value. These are all of register 0 and bits 2 and 7 of register 1.
- R4: Register 1 bit 0 is read-only status. Writes never change it. A one-cycle pulse on `hw_set` bit 8 sets it. Only a global or power reset clears it.
- R5: Register 1 bit 1 (write-only) and bit 3 (write-only, write-1-to-clear) always read as 0.
- R6: Register 1 bit 4 is read plus write-1-to-clear. Writing 1 clears it, writing 0 leaves it unchanged, and `hw_set` bit 12 sets it.
- R7: Register 1 bit 5 is read plus write-1-to-set, and bit 6 is read plus write-1-to-toggle. For both, writing 0 has no effect.
- R8: When `hw_set` bit 12 and a write of 1 to register 1 bit 4 occur in the same cycle, the bit ends up set.
- R9: Register 2 bits 0 to 2 are in the power domain. They return to 1 only while `pwr_good` is low. `glb_rst` and `sec_rst` leave them unchanged.
- R10: Register 2 bits 3 to 5 are in the secondary domain. They return to 1 on `sec_rst` or while `pwr_good` is low. `glb_rst` leaves them unchanged.
- R11: All other bits return to their default on `glb_rst`. Register 2 bits 6 and 7 take the level of `ext_lvl` bits 22 and 23 sampled while the reset is asserted.
- R12: Register 3 bits 0 to 3 belong to the primary port and bits 4 to 7 to the secondary port. The other port's writes to them are ignored, and its reads return 0 for them.
- R13: When both ports write the same register in one cycle, the primary write is applied and the secondary write is then applied to the result. Both ports writing 1 to register 1 bit 6 toggles it twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Power valid; low resets all domains |
| glb_rst | input | 1 | Global (primary-host) reset, synchronous |
| sec_rst | input | 1 | Secondary-host reset, synchronous |
| pri_addr | input | ADDR_W (2) | Primary register index |
| pri_wr | input | 1 | Primary write strobe |
| pri_wdata | input | DATA_W (8) | Primary write data |
| pri_rd | input | 1 | Primary read strobe |
| pri_rdata | output | DATA_W (8) | Primary read data, registered |
| sec_addr | input | ADDR_W (2) | Secondary register index |
| sec_wr | input | 1 | Secondary write strobe |
| sec_wdata | input | DATA_W (8) | Secondary write data |
| sec_rd | input | 1 | Secondary read strobe |
| sec_rdata | output | DATA_W (8) | Secondary read data, registered |
| hw_set | input | NUM_REGS*DATA_W (32) | Per-bit hardware set events, flat index reg*DATA_W+bit |
| ext_lvl | input | NUM_REGS*DATA_W (32) | Per-bit external default levels, same indexing |

## Verification
Some properties hold on every cycle, and the assertions check these. Read data is zero after an idle cycle. Write-only bits never read back. A port never sees bits owned by the other port. The read-only status bit only falls after a reset. A hardware set on the write-1-to-clear bit always leaves it set. The directed scenarios are needed for the rest, because each depends on a history of writes: the effect of each write policy, which bits each of the three resets restores, the sampled external defaults, and the layered result of two ports writing in the same cycle.

// File: rtl/dhrb_pkg.sv
package dhrb_pkg;

    typedef enum logic [2:0] {
        ACC_RO,
        ACC_WO,
        ACC_RW,
        ACC_WO_W1C,
        ACC_RW_W1C,
        ACC_RW_W1S,
        ACC_RW_W1T
    } access_e;

    typedef enum logic [1:0] {
        DOM_PWR,
        DOM_SEC,
        DOM_GLB
    } rdom_e;

    typedef enum logic [1:0] {
        OWN_ANY,
        OWN_PRI,
        OWN_SEC
    } owner_e;

    typedef struct packed {
        access_e acc;
        rdom_e   dom;
        owner_e  own;
        logic    dflt;
        logic    ext;
    } bit_cfg_t;

    localparam int unsigned ROLE_COUNT = 4;
    localparam int unsigned LANE_COUNT = 8;

    // Fixed bit map: role of a register repeats every ROLE_COUNT indices,
    // policy inside a register repeats every LANE_COUNT bits.
    function automatic bit_cfg_t cfg_of(int unsigned r, int unsigned b);
        bit_cfg_t c;
        int unsigned lane;
        lane   = b % LANE_COUNT;
        c.acc  = ACC_RW;
        c.dom  = DOM_GLB;
        c.own  = OWN_ANY;
        c.dflt = 1'b0;
        c.ext  = 1'b0;
        case (r % ROLE_COUNT)
            0: c.dflt = ((b % 3) == 0);
            1: begin
                case (lane)
                    0: c.acc = ACC_RO;
                    1: c.acc = ACC_WO;
                    3: c.acc = ACC_WO_W1C;
                    4: c.acc = ACC_RW_W1C;
                    5: c.acc = ACC_RW_W1S;
                    6: begin
                        c.acc  = ACC_RW_W1T;
                        c.dflt = 1'b1;
                    end
                    default: c.acc = ACC_RW;
                endcase
            end
            2: begin
                if (lane < 3) begin
                    c.dom  = DOM_PWR;
                    c.dflt = 1'b1;
                end else if (lane < 6) begin
                    c.dom  = DOM_SEC;
                    c.dflt = 1'b1;
                end else begin
                    c.ext  = 1'b1;
                end
            end
            default: c.own = (lane < 4) ? OWN_PRI : OWN_SEC;
        endcase
        return c;
    endfunction

    function automatic logic readable(access_e acc);
        return !(acc == ACC_WO || acc == ACC_WO_W1C);
    endfunction

    function automatic logic hw_settable(access_e acc);
        return (acc == ACC_RO) || (acc == ACC_WO_W1C) ||
               (acc == ACC_RW_W1C) || (acc == ACC_RW_W1S);
    endfunction

    function automatic logic port_may(owner_e own, logic is_sec);
        return (own == OWN_ANY) ||
               (own == OWN_PRI && !is_sec) ||
               (own == OWN_SEC && is_sec);
    endfunction

    // Effect of one enabled write on a single bit.
    function automatic logic write_bit(access_e acc, logic cur, logic wd);
        case (acc)
            ACC_WO, ACC_RW:         return wd;
            ACC_WO_W1C, ACC_RW_W1C: return wd ? 1'b0 : cur;
            ACC_RW_W1S:             return wd ? 1'b1 : cur;
            ACC_RW_W1T:             return wd ? ~cur : cur;
            default:                return cur;
        endcase
    endfunction

endpackage

// File: rtl/dhrb_port_gate.sv
module dhrb_port_gate
    import dhrb_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 2,
    parameter bit IS_SEC   = 1'b0
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr,
    output logic [NUM_REGS*DATA_W-1:0] wr_en
);
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic hit;
        assign hit = wr && (addr == ADDR_W'(r));
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            localparam bit_cfg_t CFG = cfg_of(r, b);
            localparam bit MAY = port_may(CFG.own, IS_SEC);
            assign wr_en[r*DATA_W+b] = MAY && hit;
        end
    end
endmodule

// File: rtl/dhrb_bit_cell.sv
module dhrb_bit_cell
    import dhrb_pkg::*;
#(
    parameter int REG_IDX = 0,
    parameter int BIT_IDX = 0
) (
    input  logic clk,
    input  logic pwr_rst,
    input  logic sec_rst,
    input  logic glb_rst,
    input  logic we_pri,
    input  logic wd_pri,
    input  logic we_sec,
    input  logic wd_sec,
    input  logic hw_set,
    input  logic ext_lvl,
    output logic q
);
    localparam bit_cfg_t CFG = cfg_of(REG_IDX, BIT_IDX);

    logic dom_rst;
    logic after_pri;
    logic after_sec;
    logic nxt;

    always_comb begin
        case (CFG.dom)
            DOM_PWR: dom_rst = pwr_rst;
            DOM_SEC: dom_rst = pwr_rst | sec_rst;
            default: dom_rst = pwr_rst | glb_rst;
        endcase
        // primary first, secondary layered on the result
        after_pri = we_pri ? write_bit(CFG.acc, q, wd_pri) : q;
        after_sec = we_sec ? write_bit(CFG.acc, after_pri, wd_sec) : after_pri;
        // hardware event outranks any clearing write
        nxt = (hw_settable(CFG.acc) && hw_set) ? 1'b1 : after_sec;
    end

    always_ff @(posedge clk) begin
        if (dom_rst) begin
            q <= CFG.ext ? ext_lvl : CFG.dflt;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/dhrb_read_port.sv
module dhrb_read_port
    import dhrb_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 2,
    parameter bit IS_SEC   = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [NUM_REGS*DATA_W-1:0] bank,
    output logic [DATA_W-1:0]          rdata
);
    logic [NUM_REGS*DATA_W-1:0] vis;
    logic [DATA_W-1:0]          sel;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            localparam bit_cfg_t CFG = cfg_of(r, b);
            localparam bit SHOW = port_may(CFG.own, IS_SEC) && readable(CFG.acc);
            assign vis[r*DATA_W+b] = SHOW && bank[r*DATA_W+b];
        end
    end

    always_comb begin
        sel = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (addr == ADDR_W'(r)) sel = vis[r*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= rd ? sel : '0;
        end
    end
endmodule

// File: rtl/dualhost_regbank.sv
module dualhost_regbank
    import dhrb_pkg::*;
#(
    parameter  int NUM_REGS = 4,
    parameter  int DATA_W   = 8,
    localparam int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int BANK_W   = NUM_REGS * DATA_W
) (
    input  logic              clk,
    input  logic              pwr_good,
    input  logic              glb_rst,
    input  logic              sec_rst,
    input  logic [ADDR_W-1:0] pri_addr,
    input  logic              pri_wr,
    input  logic [DATA_W-1:0] pri_wdata,
    input  logic              pri_rd,
    output logic [DATA_W-1:0] pri_rdata,
    input  logic [ADDR_W-1:0] sec_addr,
    input  logic              sec_wr,
    input  logic [DATA_W-1:0] sec_wdata,
    input  logic              sec_rd,
    output logic [DATA_W-1:0] sec_rdata,
    input  logic [BANK_W-1:0] hw_set,
    input  logic [BANK_W-1:0] ext_lvl
);
    logic              pwr_rst;
    logic [BANK_W-1:0] pri_we;
    logic [BANK_W-1:0] sec_we;
    logic [BANK_W-1:0] bank_q;

    assign pwr_rst = ~pwr_good;

    dhrb_port_gate #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IS_SEC(1'b0)
    ) u_pri_gate (
        .addr(pri_addr), .wr(pri_wr), .wr_en(pri_we)
    );

    dhrb_port_gate #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IS_SEC(1'b1)
    ) u_sec_gate (
        .addr(sec_addr), .wr(sec_wr), .wr_en(sec_we)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            dhrb_bit_cell #(.REG_IDX(r), .BIT_IDX(b)) u_cell (
                .clk     (clk),
                .pwr_rst (pwr_rst),
                .sec_rst (sec_rst),
                .glb_rst (glb_rst),
                .we_pri  (pri_we[r*DATA_W+b]),
                .wd_pri  (pri_wdata[b]),
                .we_sec  (sec_we[r*DATA_W+b]),
                .wd_sec  (sec_wdata[b]),
                .hw_set  (hw_set[r*DATA_W+b]),
                .ext_lvl (ext_lvl[r*DATA_W+b]),
                .q       (bank_q[r*DATA_W+b])
            );
        end
    end

    dhrb_read_port #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IS_SEC(1'b0)
    ) u_pri_read (
        .clk(clk), .rst(pwr_rst), .rd(pri_rd), .addr(pri_addr),
        .bank(bank_q), .rdata(pri_rdata)
    );

    dhrb_read_port #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IS_SEC(1'b1)
    ) u_sec_read (
        .clk(clk), .rst(pwr_rst), .rd(sec_rd), .addr(sec_addr),
        .bank(bank_q), .rdata(sec_rdata)
    );
endmodule

// File: rtl/dhrb_checker.sv
module dhrb_checker #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 2
) (
    input logic              clk,
    input logic              pwr_good,
    input logic              glb_rst,
    input logic [ADDR_W-1:0] pri_addr,
    input logic              pri_rd,
    input logic [DATA_W-1:0] pri_rdata,
    input logic [ADDR_W-1:0] sec_addr,
    input logic              sec_rd,
    input logic [DATA_W-1:0] sec_rdata,
    input logic              hw_set_w1c,
    input logic              ro_q,
    input logic              w1c_q
);
    localparam logic [DATA_W-1:0] WO_MASK  = DATA_W'(8'h0A);
    localparam logic [DATA_W-1:0] PRI_MASK = DATA_W'(8'h0F);
    localparam logic [DATA_W-1:0] SEC_MASK = DATA_W'(8'hF0);

    assert_rdata_idle_zero_R1: assert property (@(posedge clk) disable iff (!pwr_good)
        !$past(pri_rd) |-> (pri_rdata == '0));

    assert_sec_rdata_idle_zero_R1: assert property (@(posedge clk) disable iff (!pwr_good)
        !$past(sec_rd) |-> (sec_rdata == '0));

    assert_ro_falls_on_reset_R4: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(ro_q) |-> ($past(glb_rst) || !$past(pwr_good)));

    assert_hw_set_wins_R8: assert property (@(posedge clk) disable iff (!pwr_good)
        ($past(pwr_good) && !$past(glb_rst) && $past(hw_set_w1c)) |-> w1c_q);

    if (NUM_REGS >= 4) begin : g_map
        assert_wo_reads_zero_R5: assert property (@(posedge clk) disable iff (!pwr_good)
            $past(pri_rd && pri_addr == ADDR_W'(1)) |-> ((pri_rdata & WO_MASK) == '0));

        assert_pri_hides_sec_bits_R12: assert property (@(posedge clk) disable iff (!pwr_good)
            $past(pri_rd && pri_addr == ADDR_W'(3)) |-> ((pri_rdata & SEC_MASK) == '0));

        assert_sec_hides_pri_bits_R12: assert property (@(posedge clk) disable iff (!pwr_good)
            $past(sec_rd && sec_addr == ADDR_W'(3)) |-> ((sec_rdata & PRI_MASK) == '0));
    end
endmodule

bind dualhost_regbank dhrb_checker #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_dhrb_checker (
    .clk        (clk),
    .pwr_good   (pwr_good),
    .glb_rst    (glb_rst),
    .pri_addr   (pri_addr),
    .pri_rd     (pri_rd),
    .pri_rdata  (pri_rdata),
    .sec_addr   (sec_addr),
    .sec_rd     (sec_rd),
    .sec_rdata  (sec_rdata),
    .hw_set_w1c (hw_set[DATA_W+4]),
    .ro_q       (bank_q[DATA_W]),
    .w1c_q      (bank_q[DATA_W+4])
);

// File: tb/dualhost_regbank_test.sv
module dualhost_regbank_test;
    logic        clk = 1'b0;
    logic        pwr_good = 1'b0;
    logic        glb_rst = 1'b0;
    logic        sec_rst = 1'b0;
    logic [1:0]  pri_addr = '0;
    logic        pri_wr = 1'b0;
    logic [7:0]  pri_wdata = '0;
    logic        pri_rd = 1'b0;
    logic [7:0]  pri_rdata;
    logic [1:0]  sec_addr = '0;
    logic        sec_wr = 1'b0;
    logic [7:0]  sec_wdata = '0;
    logic        sec_rd = 1'b0;
    logic [7:0]  sec_rdata;
    logic [31:0] hw_set = '0;
    logic [31:0] ext_lvl = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] d;

    dualhost_regbank uut (
        .clk(clk), .pwr_good(pwr_good), .glb_rst(glb_rst), .sec_rst(sec_rst),
        .pri_addr(pri_addr), .pri_wr(pri_wr), .pri_wdata(pri_wdata),
        .pri_rd(pri_rd), .pri_rdata(pri_rdata),
        .sec_addr(sec_addr), .sec_wr(sec_wr), .sec_wdata(sec_wdata),
        .sec_rd(sec_rd), .sec_rdata(sec_rdata),
        .hw_set(hw_set), .ext_lvl(ext_lvl)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, got, exp);
        end
    endtask

    task automatic pri_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); pri_addr = a; pri_wdata = v; pri_wr = 1'b1;
        @(negedge clk); pri_wr = 1'b0;
    endtask

    task automatic sec_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); sec_addr = a; sec_wdata = v; sec_wr = 1'b1;
        @(negedge clk); sec_wr = 1'b0;
    endtask

    task automatic both_write(input logic [1:0] a, input logic [7:0] vp, input logic [7:0] vs);
        @(negedge clk);
        pri_addr = a; pri_wdata = vp; pri_wr = 1'b1;
        sec_addr = a; sec_wdata = vs; sec_wr = 1'b1;
        @(negedge clk); pri_wr = 1'b0; sec_wr = 1'b0;
    endtask

    task automatic pri_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); pri_addr = a; pri_rd = 1'b1;
        @(negedge clk); pri_rd = 1'b0; v = pri_rdata;
    endtask

    task automatic sec_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); sec_addr = a; sec_rd = 1'b1;
        @(negedge clk); sec_rd = 1'b0; v = sec_rdata;
    endtask

    task automatic pulse_hw(input int idx);
        @(negedge clk); hw_set[idx] = 1'b1;
        @(negedge clk); hw_set[idx] = 1'b0;
    endtask

    task automatic test_reset_defaults;
        ext_lvl[23:22] = 2'b10;
        pwr_good = 1'b0;
        repeat (3) @(negedge clk);
        pwr_good = 1'b1;
        @(negedge clk);
        check("R1 idle read data", pri_rdata, 8'h00);
        pri_read(2'd0, d); check("R2 reg0 default", d, 8'h49);
        pri_read(2'd1, d); check("R2 reg1 default", d, 8'h40);
        pri_read(2'd2, d); check("R2/R11 reg2 default with ext", d, 8'hBF);
        pri_read(2'd3, d); check("R2 reg3 default", d, 8'h00);
    endtask

    task automatic test_rw;
        pri_write(2'd0, 8'h3C);
        pri_read(2'd0, d); check("R3 reg0 write", d, 8'h3C);
        pri_write(2'd1, 8'h84);
        pri_read(2'd1, d); check("R3 reg1 rw bits", d & 8'h84, 8'h84);
    endtask

    task automatic test_ro;
        pri_write(2'd1, 8'h01);
        pri_read(2'd1, d); check("R4 ro ignores write", d & 8'h01, 8'h00);
        pulse_hw(8);
        pri_read(2'd1, d); check("R4 ro set by hw", d & 8'h01, 8'h01);
        pri_write(2'd1, 8'h00);
        pri_read(2'd1, d); check("R4 ro holds after write 0", d & 8'h01, 8'h01);
    endtask

    task automatic test_wo;
        pri_write(2'd1, 8'h0A);
        pri_read(2'd1, d); check("R5 write-only bits read 0", d & 8'h0A, 8'h00);
    endtask

    task automatic test_w1c;
        pulse_hw(12);
        pri_read(2'd1, d); check("R6 w1c set by hw", d & 8'h10, 8'h10);
        pri_write(2'd1, 8'h00);
        pri_read(2'd1, d); check("R6 w1c write 0 no effect", d & 8'h10, 8'h10);
        pri_write(2'd1, 8'h10);
        pri_read(2'd1, d); check("R6 w1c write 1 clears", d & 8'h10, 8'h00);
    endtask

    task automatic test_w1s_w1t;
        pri_write(2'd1, 8'h20);
        pri_read(2'd1, d); check("R7 w1s sets", d & 8'h20, 8'h20);
        pri_write(2'd1, 8'h00);
        pri_read(2'd1, d); check("R7 w1s write 0 keeps", d & 8'h60, 8'h60);
        pri_write(2'd1, 8'h40);
        pri_read(2'd1, d); check("R7 w1t toggles low", d & 8'h40, 8'h00);
        pri_write(2'd1, 8'h40);
        pri_read(2'd1, d); check("R7 w1t toggles high", d & 8'h40, 8'h40);
    endtask

    task automatic test_hw_priority;
        @(negedge clk);
        pri_addr = 2'd1; pri_wdata = 8'h10; pri_wr = 1'b1; hw_set[12] = 1'b1;
        @(negedge clk);
        pri_wr = 1'b0; hw_set[12] = 1'b0;
        pri_read(2'd1, d); check("R8 hw set beats w1c", d & 8'h10, 8'h10);
    endtask

    task automatic test_domains;
        pri_write(2'd2, 8'h00);
        pri_read(2'd2, d); check("R9 reg2 cleared by write", d, 8'h00);
        ext_lvl[23:22] = 2'b01;
        @(negedge clk); glb_rst = 1'b1;
        @(negedge clk); glb_rst = 1'b0;
        pri_read(2'd2, d); check("R9/R10/R11 glb_rst on reg2", d, 8'h40);
        pri_read(2'd0, d); check("R11 glb_rst restores reg0", d, 8'h49);
        pri_read(2'd1, d); check("R11 glb_rst restores reg1", d, 8'h40);
        pri_write(2'd2, 8'h00);
        @(negedge clk); sec_rst = 1'b1;
        @(negedge clk); sec_rst = 1'b0;
        pri_read(2'd2, d); check("R10 sec_rst restores sec bits only", d, 8'h38);
        @(negedge clk); pwr_good = 1'b0;
        @(negedge clk); pwr_good = 1'b1;
        pri_read(2'd2, d); check("R9 power restores all reg2", d, 8'h7F);
    endtask

    task automatic test_ownership;
        pri_write(2'd3, 8'hFF);
        pri_read(2'd3, d); check("R12 pri sees own bits", d, 8'h0F);
        sec_read(2'd3, d); check("R12 sec blind to pri bits", d, 8'h00);
        sec_write(2'd3, 8'hFF);
        sec_read(2'd3, d); check("R12 sec sees own bits", d, 8'hF0);
        pri_write(2'd3, 8'h00);
        pri_read(2'd3, d); check("R12 pri write clears own", d, 8'h00);
        sec_read(2'd3, d); check("R12 pri write ignored on sec bits", d, 8'hF0);
    endtask

    task automatic test_collision;
        both_write(2'd0, 8'h12, 8'h34);
        pri_read(2'd0, d); check("R13 secondary layered last", d, 8'h34);
        both_write(2'd1, 8'h40, 8'h40);
        pri_read(2'd1, d); check("R13 double toggle", d & 8'h40, 8'h40);
        both_write(2'd1, 8'h40, 8'h00);
        sec_read(2'd1, d); check("R13 single toggle", d & 8'h40, 8'h00);
    endtask

    task automatic test_read_timing;
        @(negedge clk);
        pri_addr = 2'd0; pri_rd = 1'b1;
        sec_addr = 2'd0; sec_wdata = 8'h77; sec_wr = 1'b1;
        @(negedge clk);
        pri_rd = 1'b0; sec_wr = 1'b0;
        check("R1 read returns pre-write value", pri_rdata, 8'h34);
        @(negedge clk);
        check("R1 read data zero after idle", pri_rdata, 8'h00);
        pri_read(2'd0, d); check("R1 later read sees write", d, 8'h77);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset_defaults();
        test_rw();
        test_ro();
        test_wo();
        test_w1c();
        test_w1s_w1t();
        test_hw_priority();
        test_domains();
        test_ownership();
        test_collision();
        test_read_timing();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule